// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing side of a simple two-port keyboard controller. The host sees two byte-wide ports chosen by one select bit. Select 0 is the data port and select 1 is the command/status port. Any host write lands in a one-byte input buffer. A small controller state machine takes that byte after a fixed processing delay and acts on it. A command may read or write one byte of a small internal RAM, or switch the keyboard or mouse receive side on or off. A data byte goes either into a RAM byte that an earlier command selected, or out to the keyboard as a transmit pulse.

A single one-byte output buffer is shared by three producers: command responses, keyboard receive bytes and mouse receive bytes. When more than one is ready, a command response is taken first, then a keyboard byte, then a mouse byte. A producer that cannot enter is held off with a busy flag until the host empties the buffer through the data port. The producer of the byte currently held decides which interrupt line is raised. Both interrupt lines fall when the host reads the byte.

Controller states: `ST_IDLE` (input buffer empty), `ST_DELAY` (counting `PROC_LAT` clocks), `ST_EXEC` (decode and act), `ST_RESP` (a RAM read response waits for the output buffer to empty). The transitions are:
- `ST_IDLE` to `ST_DELAY` when the input buffer fills.
- `ST_DELAY` to `ST_EXEC` after `PROC_LAT` clocks.
- `ST_EXEC` to `ST_IDLE` once the byte is consumed, or to `ST_RESP` when the output buffer is full.
- `ST_RESP` to `ST_IDLE` when the response is loaded.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x00, both interrupt lines are low, and both clock enables `kbd_clk_en` and `aux_clk_en` are high.
- R2: A host write to either port sets status bit 1 (input full). The write sets status bit 3 to 1 for the command port and to 0 for the data port. A write made while bit 1 is set is discarded. Bit 1 clears within PROC_LAT+4 clocks unless a response waits on a full output buffer.
- R3: With select 1, `host_rdata` is the status byte and no buffer changes. With select 0, `host_rdata` is the output byte, and a read strobe clears status bit 0 (output full).
- R4: Command 0x20+n (n below RAM_DEPTH) loads RAM byte n into the output buffer. Status bit 5 is 0 and `irq_kbd` is high for this response. After reset RAM byte 0 holds CFG_RESET (default 0x45) and every other byte holds 0.
- R5: Command 0x60+n makes the next data-port write store into RAM byte n. That byte is not sent to the keyboard, and it is read back by command 0x20+n.
- R6: A data-port write with no RAM write pending produces exactly one `kbd_tx_valid` pulse that carries the byte.
- R7: Command 0xAD drives `kbd_clk_en` low, and no keyboard byte enters the output buffer while it is low. Command 0xAE drives it high again.
- R8: Command 0xA7 drives `aux_clk_en` low, and no mouse byte enters while it is low. Command 0xA8 drives it high again.
- R9: A keyboard byte in the output buffer gives status bit 5 = 0, `irq_kbd` = 1 and `irq_aux` = 0. A mouse byte gives bit 5 = 1, `irq_aux` = 1 and `irq_kbd` = 0.
- R10: While the output buffer is full, an offered device byte sees its busy output high and is held off until a data read frees the buffer. When producers are ready together, the order is command response, then keyboard, then mouse.
- R11: Both interrupt lines are low whenever the output buffer is empty, so they fall after a data-port read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Port select: 0 data, 1 command/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (acts on the data port only) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte (select 1) or output byte (select 0) |
| kbd_rx_valid | input | 1 | Keyboard side offers a byte |
| kbd_rx_data | input | 8 | Keyboard byte |
| kbd_rx_busy | output | 1 | Keyboard byte not taken this cycle |
| aux_rx_valid | input | 1 | Mouse side offers a byte |
| aux_rx_data | input | 8 | Mouse byte |
| aux_rx_busy | output | 1 | Mouse byte not taken this cycle |
| kbd_clk_en | output | 1 | Keyboard port clock enable |
| aux_clk_en | output | 1 | Mouse port clock enable |
| kbd_tx_valid | output | 1 | One-cycle pulse: byte for the keyboard |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| irq_kbd | output | 1 | Output byte from keyboard or command response |
| irq_aux | output | 1 | Output byte from the mouse |

## Verification
The checker assumes the host obeys the status contract. It writes only when bit 1 reads clear and reads the data port only when bit 0 reads set. The one exception is a write deliberately issued into a full input buffer, which the dropped-write property covers. The checker also assumes a device keeps its byte and valid steady until it sees the byte taken. The stimulus meets these assumptions by polling status before every access. It drops a device's valid only after status shows the buffer filled, and it chooses random RAM indices only below the RAM depth.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    typedef enum logic [1:0] {SRC_KBD, SRC_AUX, SRC_CMD} src_e;
    typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_EXEC, ST_RESP} ctrl_st_e;
    typedef enum logic [3:0] {
        OP_NOP, OP_RD_RAM, OP_SET_WR, OP_RAM_WR, OP_FWD,
        OP_KBD_OFF, OP_KBD_ON, OP_AUX_OFF, OP_AUX_ON
    } op_e;

    localparam logic [7:0] CMD_RD_BASE = 8'h20;
    localparam logic [7:0] CMD_WR_BASE = 8'h60;
    localparam logic [7:0] CMD_KBD_OFF = 8'hAD;
    localparam logic [7:0] CMD_KBD_ON  = 8'hAE;
    localparam logic [7:0] CMD_AUX_OFF = 8'hA7;
    localparam logic [7:0] CMD_AUX_ON  = 8'hA8;

    localparam int STB_OBF = 0;
    localparam int STB_IBF = 1;
    localparam int STB_CMD = 3;
    localparam int STB_AUX = 5;
endpackage

// File: rtl/kbc_ram.sv
module kbc_ram #(
    parameter int          DEPTH  = 32,
    parameter int          WIDTH  = 8,
    parameter logic [7:0]  RESET0 = 8'h45,
    localparam int         AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            localparam logic [WIDTH-1:0] INIT = (g == 0) ? WIDTH'(RESET0) : '0;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= INIT;
                else if (we && (addr == AW'(g)))
                    mem[g] <= wdata;
            end
        end
    endgenerate

    assign rdata = mem[addr];
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf
    import kbc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_clr,
    input  logic         resp_load,
    input  logic [W-1:0] resp_data,
    input  logic         kbd_valid,
    input  logic         kbd_en,
    input  logic [W-1:0] kbd_data,
    input  logic         aux_valid,
    input  logic         aux_en,
    input  logic [W-1:0] aux_data,
    output logic         kbd_take,
    output logic         aux_take,
    output logic         full,
    output logic [W-1:0] data,
    output src_e         src
);
    // fixed priority: command response, keyboard, mouse
    always_comb begin
        kbd_take = kbd_valid && kbd_en && !full && !resp_load;
        aux_take = aux_valid && aux_en && !full && !resp_load && !kbd_take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            src  <= SRC_KBD;
        end else begin
            if (rd_clr)
                full <= 1'b0;
            if (resp_load) begin
                full <= 1'b1;
                data <= resp_data;
                src  <= SRC_CMD;
            end else if (kbd_take) begin
                full <= 1'b1;
                data <= kbd_data;
                src  <= SRC_KBD;
            end else if (aux_take) begin
                full <= 1'b1;
                data <= aux_data;
                src  <= SRC_AUX;
            end
        end
    end
endmodule

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
    import kbc_pkg::*;
#(
    parameter int  RAM_DEPTH = 32,
    parameter int  PROC_LAT  = 4,
    localparam int AW        = $clog2(RAM_DEPTH),
    localparam int CW        = $clog2(PROC_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          obuf_full,
    output logic          ibuf_full,
    output logic          ibuf_is_cmd,
    output logic [7:0]    ibuf_data,
    output logic          kbd_en,
    output logic          aux_en,
    output logic          resp_load,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          tx_valid
);
    localparam logic [8:0]    DEPTH9   = 9'(RAM_DEPTH);
    localparam logic [CW-1:0] LAT_LAST = CW'(PROC_LAT - 1);

    ctrl_st_e      state, nxt;
    op_e           op;
    logic [CW-1:0] cnt;
    logic          ibuf_clr;
    logic          wr_pend;
    logic [AW-1:0] wr_idx;
    logic [7:0]    rd_off, wr_off;

    // decode of the byte held in the input buffer
    always_comb begin
        rd_off = ibuf_data - CMD_RD_BASE;
        wr_off = ibuf_data - CMD_WR_BASE;
        op     = OP_NOP;
        if (!ibuf_is_cmd)
            op = wr_pend ? OP_RAM_WR : OP_FWD;
        else if (ibuf_data >= CMD_RD_BASE && {1'b0, rd_off} < DEPTH9)
            op = OP_RD_RAM;
        else if (ibuf_data >= CMD_WR_BASE && {1'b0, wr_off} < DEPTH9)
            op = OP_SET_WR;
        else if (ibuf_data == CMD_KBD_OFF) op = OP_KBD_OFF;
        else if (ibuf_data == CMD_KBD_ON)  op = OP_KBD_ON;
        else if (ibuf_data == CMD_AUX_OFF) op = OP_AUX_OFF;
        else if (ibuf_data == CMD_AUX_ON)  op = OP_AUX_ON;
        ram_addr = (op == OP_RAM_WR) ? wr_idx : rd_off[AW-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        ibuf_clr  = 1'b0;
        resp_load = 1'b0;
        ram_we    = 1'b0;
        tx_valid  = 1'b0;
        unique case (state)
            ST_IDLE:  if (ibuf_full) nxt = ST_DELAY;
            ST_DELAY: if (cnt == LAT_LAST) nxt = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_RD_RAM) begin
                    if (obuf_full) begin
                        nxt = ST_RESP;
                    end else begin
                        resp_load = 1'b1;
                        ibuf_clr  = 1'b1;
                        nxt       = ST_IDLE;
                    end
                end else begin
                    ibuf_clr = 1'b1;
                    ram_we   = (op == OP_RAM_WR);
                    tx_valid = (op == OP_FWD);
                    nxt      = ST_IDLE;
                end
            end
            ST_RESP: begin
                if (!obuf_full) begin
                    resp_load = 1'b1;
                    ibuf_clr  = 1'b1;
                    nxt       = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // input buffer, delay counter, port enables, pending RAM write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_full   <= 1'b0;
            ibuf_is_cmd <= 1'b0;
            ibuf_data   <= '0;
            cnt         <= '0;
            kbd_en      <= 1'b1;
            aux_en      <= 1'b1;
            wr_pend     <= 1'b0;
            wr_idx      <= '0;
        end else begin
            if (ibuf_clr) begin
                ibuf_full <= 1'b0;
            end else if (host_wr && !ibuf_full) begin
                ibuf_full   <= 1'b1;
                ibuf_is_cmd <= host_sel;
                ibuf_data   <= host_wdata;
            end

            if (state == ST_DELAY) cnt <= cnt + 1'b1;
            else                   cnt <= '0;

            if (state == ST_EXEC) begin
                unique case (op)
                    OP_KBD_OFF: kbd_en <= 1'b0;
                    OP_KBD_ON:  kbd_en <= 1'b1;
                    OP_AUX_OFF: aux_en <= 1'b0;
                    OP_AUX_ON:  aux_en <= 1'b1;
                    default: ;
                endcase
                if (op == OP_SET_WR) begin
                    wr_pend <= 1'b1;
                    wr_idx  <= wr_off[AW-1:0];
                end else if (ibuf_is_cmd || op == OP_RAM_WR) begin
                    wr_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int         RAM_DEPTH = 32,
    parameter int         PROC_LAT  = 4,
    parameter logic [7:0] CFG_RESET = 8'h45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       kbd_rx_valid,
    input  logic [7:0] kbd_rx_data,
    output logic       kbd_rx_busy,
    input  logic       aux_rx_valid,
    input  logic [7:0] aux_rx_data,
    output logic       aux_rx_busy,
    output logic       kbd_clk_en,
    output logic       aux_clk_en,
    output logic       kbd_tx_valid,
    output logic [7:0] kbd_tx_data,
    output logic       irq_kbd,
    output logic       irq_aux
);
    localparam int AW = $clog2(RAM_DEPTH);

    logic          ibuf_full, ibuf_is_cmd, resp_load, ram_we;
    logic [7:0]    ibuf_data, ram_rdata, obuf_data;
    logic [AW-1:0] ram_addr;
    logic          obuf_full, kbd_take, aux_take, rd_clr;
    src_e          obuf_src;
    logic [7:0]    status;

    assign rd_clr = host_rd && !host_sel;

    kbc_ctrl #(.RAM_DEPTH(RAM_DEPTH), .PROC_LAT(PROC_LAT)) u_ctrl (
        .clk, .rst_n, .host_sel, .host_wr, .host_wdata,
        .obuf_full, .ibuf_full, .ibuf_is_cmd, .ibuf_data,
        .kbd_en(kbd_clk_en), .aux_en(aux_clk_en),
        .resp_load, .ram_we, .ram_addr, .tx_valid(kbd_tx_valid)
    );

    kbc_ram #(.DEPTH(RAM_DEPTH), .WIDTH(8), .RESET0(CFG_RESET)) u_ram (
        .clk, .rst_n, .we(ram_we), .addr(ram_addr),
        .wdata(ibuf_data), .rdata(ram_rdata)
    );

    kbc_obuf #(.W(8)) u_obuf (
        .clk, .rst_n, .rd_clr, .resp_load, .resp_data(ram_rdata),
        .kbd_valid(kbd_rx_valid), .kbd_en(kbd_clk_en), .kbd_data(kbd_rx_data),
        .aux_valid(aux_rx_valid), .aux_en(aux_clk_en), .aux_data(aux_rx_data),
        .kbd_take, .aux_take, .full(obuf_full), .data(obuf_data), .src(obuf_src)
    );

    always_comb begin
        status          = '0;
        status[STB_OBF] = obuf_full;
        status[STB_IBF] = ibuf_full;
        status[STB_CMD] = ibuf_is_cmd;
        status[STB_AUX] = (obuf_src == SRC_AUX);
    end

    assign host_rdata  = host_sel ? status : obuf_data;
    assign kbd_tx_data = ibuf_data;
    assign kbd_rx_busy = kbd_rx_valid && !kbd_take;
    assign aux_rx_busy = aux_rx_valid && !aux_take;
    assign irq_kbd     = obuf_full && (obuf_src != SRC_AUX);
    assign irq_aux     = obuf_full && (obuf_src == SRC_AUX);
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk
    import kbc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel,
    input logic       host_rd,
    input logic       host_wr,
    input logic       kbd_rx_valid,
    input logic       kbd_rx_busy,
    input logic       aux_rx_valid,
    input logic       aux_rx_busy,
    input logic       kbd_clk_en,
    input logic       irq_kbd,
    input logic       irq_aux,
    input logic       obuf_full,
    input logic       ibuf_full,
    input logic [7:0] ibuf_data,
    input src_e       obuf_src
);
    assert_write_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ibuf_full && host_wr |=> ibuf_data == $past(ibuf_data));

    assert_status_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_full && host_sel |=> obuf_full);

    assert_data_read_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_full && host_rd && !host_sel |=> !obuf_full);

    assert_kbd_off_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_clk_en && !obuf_full |=> !(obuf_full && obuf_src == SRC_KBD));

    assert_irq_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_kbd && irq_aux));

    assert_kbd_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_full && kbd_rx_valid |-> kbd_rx_busy);

    assert_aux_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        obuf_full && aux_rx_valid |-> aux_rx_busy);

    assert_irq_needs_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_kbd || irq_aux) |-> obuf_full);
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
    .host_wr(host_wr), .kbd_rx_valid(kbd_rx_valid), .kbd_rx_busy(kbd_rx_busy),
    .aux_rx_valid(aux_rx_valid), .aux_rx_busy(aux_rx_busy),
    .kbd_clk_en(kbd_clk_en), .irq_kbd(irq_kbd), .irq_aux(irq_aux),
    .obuf_full(obuf_full), .ibuf_full(ibuf_full), .ibuf_data(ibuf_data),
    .obuf_src(obuf_src)
);

// File: tb/test_kbc_host_if.sv
module test_kbc_host_if;
    localparam int         CLK_PERIOD = 10;
    localparam int         DEPTH      = 32;
    localparam logic [7:0] CFG0       = 8'h45;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_sel = 1'b1, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic kbd_rx_valid = 1'b0, aux_rx_valid = 1'b0;
    logic [7:0] kbd_rx_data = '0, aux_rx_data = '0;
    logic kbd_rx_busy, aux_rx_busy, kbd_clk_en, aux_clk_en;
    logic kbd_tx_valid, irq_kbd, irq_aux;
    logic [7:0] kbd_tx_data;

    int checks = 0, errors = 0, tx_cnt = 0;
    logic [7:0] tx_last = '0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbc_host_if i_kbc_host_if (
        .clk, .rst_n, .host_sel, .host_wr, .host_rd, .host_wdata, .host_rdata,
        .kbd_rx_valid, .kbd_rx_data, .kbd_rx_busy,
        .aux_rx_valid, .aux_rx_data, .aux_rx_busy,
        .kbd_clk_en, .aux_clk_en, .kbd_tx_valid, .kbd_tx_data,
        .irq_kbd, .irq_aux
    );

    always @(negedge clk) if (kbd_tx_valid) begin
        tx_cnt++;
        tx_last = kbd_tx_data;
    end

    function automatic logic [7:0] exp_status(logic obf, logic ibf, logic aux, logic cmd);
        return {2'b00, aux, 1'b0, cmd, 1'b0, ibf, obf};
    endfunction

    task automatic check(logic ok, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd_status(output logic [7:0] s);
        host_sel = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic wait_stat(int b, logic v, string req);
        logic [7:0] s;
        int n = 0;
        rd_status(s);
        while (s[b] !== v && n < 60) begin
            step();
            rd_status(s);
            n++;
        end
        check(s[b] === v, req, s, {7'd0, v});
    endtask

    task automatic host_write(logic sel, logic [7:0] d);
        wait_stat(1, 1'b0, "R2 input buffer drains");
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0; host_sel = 1'b1;
    endtask

    task automatic read_data(output logic [7:0] d);
        wait_stat(0, 1'b1, "R3 output buffer fills");
        host_sel = 1'b0;
        #1 d = host_rdata;
        host_rd = 1'b1;
        step();
        host_rd = 1'b0; host_sel = 1'b1;
    endtask

    task automatic ram_read_chk(int n, logic [7:0] exp, string req);
        logic [7:0] s, d;
        host_write(1'b1, CMD_BASE_RD + 8'(n));
        wait_stat(0, 1'b1, req);
        rd_status(s);
        check(s == exp_status(1, 0, 0, 1), {req, " response status"}, s, exp_status(1, 0, 0, 1));
        check(irq_kbd && !irq_aux, {req, " response irq"}, {6'd0, irq_aux, irq_kbd}, 8'h01);
        read_data(d);
        check(d == exp, req, d, exp);
    endtask

    localparam logic [7:0] CMD_BASE_RD = 8'h20;
    localparam logic [7:0] CMD_BASE_WR = 8'h60;

    task automatic dev_byte(logic is_aux, logic [7:0] v, logic last_cmd);
        logic [7:0] s, d;
        if (is_aux) begin aux_rx_data = v; aux_rx_valid = 1'b1; end
        else        begin kbd_rx_data = v; kbd_rx_valid = 1'b1; end
        wait_stat(0, 1'b1, "R9 device byte enters");
        aux_rx_valid = 1'b0; kbd_rx_valid = 1'b0;
        rd_status(s);
        check(s == exp_status(1, 0, is_aux, last_cmd), "R9 status source bit", s,
              exp_status(1, 0, is_aux, last_cmd));
        check(irq_aux == is_aux && irq_kbd == !is_aux, "R9 irq routing",
              {6'd0, irq_aux, irq_kbd}, {6'd0, is_aux, !is_aux});
        read_data(d);
        check(d == v, "R9 device byte value", d, v);
        check(!irq_kbd && !irq_aux, "R11 irq falls after read", {6'd0, irq_aux, irq_kbd}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int t0;
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) model[i] = (i == 0) ? CFG0 : 8'h00;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd_status(s);
        check(s == 8'h00, "R1 reset status", s, 8'h00);
        check(!irq_kbd && !irq_aux, "R1 irqs low", {6'd0, irq_aux, irq_kbd}, 8'h00);
        check(kbd_clk_en && aux_clk_en, "R1 clock enables", {6'd0, aux_clk_en, kbd_clk_en}, 8'h03);

        // R4 configuration byte and an untouched byte
        ram_read_chk(0, CFG0, "R4 ram byte 0");
        ram_read_chk(3, 8'h00, "R4 ram byte 3");
        check(!irq_kbd && !irq_aux, "R11 irq low after response read", {6'd0, irq_aux, irq_kbd}, 8'h00);

        // R2 status flags right after a write
        host_write(1'b0, 8'h5A);
        rd_status(s);
        check(s == exp_status(0, 1, 0, 0), "R2 data write flags", s, exp_status(0, 1, 0, 0));
        wait_stat(1, 1'b0, "R2 data write drains");
        // R6 forwarded byte
        check(tx_cnt == 1 && tx_last == 8'h5A, "R6 forwarded byte", tx_last, 8'h5A);

        // R2 dropped write and R7 keyboard off
        host_write(1'b1, 8'hAD);
        rd_status(s);
        check(s == exp_status(0, 1, 0, 1), "R2 command write flags", s, exp_status(0, 1, 0, 1));
        host_sel = 1'b1; host_wdata = 8'hA7; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
        wait_stat(1, 1'b0, "R2 command drains");
        check(!kbd_clk_en && aux_clk_en, "R2 second write discarded, R7 keyboard off",
              {6'd0, aux_clk_en, kbd_clk_en}, 8'h02);

        // R7 keyboard byte not accepted while disabled
        kbd_rx_data = 8'h1C; kbd_rx_valid = 1'b1;
        repeat (20) step();
        rd_status(s);
        check(s[0] == 1'b0 && kbd_rx_busy, "R7 keyboard held while disabled", s, 8'h08);
        host_write(1'b1, 8'hAE);
        wait_stat(0, 1'b1, "R7 keyboard byte after enable");
        kbd_rx_valid = 1'b0;
        check(kbd_clk_en, "R7 keyboard re-enabled", {7'd0, kbd_clk_en}, 8'h01);
        read_data(d);
        check(d == 8'h1C, "R7 held keyboard byte", d, 8'h1C);

        // R8 mouse off and on
        host_write(1'b1, 8'hA7);
        wait_stat(1, 1'b0, "R8 command drains");
        check(!aux_clk_en, "R8 mouse off", {7'd0, aux_clk_en}, 8'h00);
        aux_rx_data = 8'h08; aux_rx_valid = 1'b1;
        repeat (15) step();
        rd_status(s);
        check(s[0] == 1'b0, "R8 mouse byte blocked", s, 8'h08);
        host_write(1'b1, 8'hA8);
        wait_stat(0, 1'b1, "R8 mouse byte after enable");
        aux_rx_valid = 1'b0;
        rd_status(s);
        check(s == exp_status(1, 0, 1, 1), "R8 R9 mouse byte status", s, exp_status(1, 0, 1, 1));
        check(irq_aux && !irq_kbd, "R9 mouse irq", {6'd0, irq_aux, irq_kbd}, 8'h02);
        read_data(d);
        check(d == 8'h08, "R8 mouse byte value", d, 8'h08);

        // R10 held off while full
        kbd_rx_data = 8'h2A; kbd_rx_valid = 1'b1;
        wait_stat(0, 1'b1, "R10 keyboard fills");
        kbd_rx_valid = 1'b0;
        aux_rx_data = 8'h09; aux_rx_valid = 1'b1;
        t0 = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            rd_status(s);
            if (!aux_rx_busy || s[5]) t0++;
        end
        check(t0 == 0, "R10 mouse busy while full", 8'(t0), 8'h00);
        read_data(d);
        check(d == 8'h2A, "R10 first byte kept", d, 8'h2A);
        wait_stat(0, 1'b1, "R10 mouse enters after read");
        aux_rx_valid = 1'b0;
        read_data(d);
        check(d == 8'h09, "R10 mouse byte after read", d, 8'h09);

        // R10 keyboard wins over mouse
        kbd_rx_data = 8'h11; aux_rx_data = 8'h22;
        kbd_rx_valid = 1'b1; aux_rx_valid = 1'b1;
        read_data(d);
        kbd_rx_valid = 1'b0;
        check(d == 8'h11, "R10 keyboard before mouse", d, 8'h11);
        wait_stat(0, 1'b1, "R10 mouse follows");
        aux_rx_valid = 1'b0;
        read_data(d);
        check(d == 8'h22, "R10 mouse second", d, 8'h22);

        // R5 RAM write not forwarded
        t0 = tx_cnt;
        host_write(1'b1, CMD_BASE_WR + 8'd5);
        host_write(1'b0, 8'h77);
        wait_stat(1, 1'b0, "R5 write drains");
        model[5] = 8'h77;
        check(tx_cnt == t0, "R5 not forwarded", 8'(tx_cnt - t0), 8'h00);
        ram_read_chk(5, 8'h77, "R5 ram read back");

        // random RAM traffic and device bytes
        for (int i = 0; i < 16; i++) begin
            int n;
            logic [7:0] v;
            n = int'($urandom % DEPTH);
            v = 8'($urandom);
            host_write(1'b1, CMD_BASE_WR + 8'(n));
            host_write(1'b0, v);
            model[n] = v;
            ram_read_chk(n, model[n], "R5 random ram");
        end
        for (int i = 0; i < 12; i++) begin
            dev_byte(1'($urandom), 8'($urandom), 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule